// File: doc/BRIEF.md
# Two-Class Dual-Issue Slot Controller

This block sits at the issue stage of an in-order core. Each cycle it sees one aligned fetch pair of up to two instructions. Each instruction carries a class bit that was worked out when the line was filled and stored beside it. The class bit says whether the instruction is a floating-point ALU operation or belongs to the general class. The block lets at most one instruction of each class issue per cycle, so a mixed pair goes out together. Data dependencies between the two classes never hold back a pair.

Two long-latency units are tracked: the floating-point divide/square-root unit and the integer multiply/divide unit. Each has a down-counter that is loaded when an operation for that unit issues. An instruction that needs a busy unit holds in place, and the block raises a slip flag. The younger instruction of the pair never overtakes an older one that is waiting. The fetch side holds the pair until the block asserts the advance flag. That happens in the cycle in which the last outstanding valid slot of the pair issues. Slots that have already issued are remembered and are not issued again.

Top module: `slot_issue_ctl`

## Requirements
- R1: After a synchronous reset, no unit is busy and no slot of the first pair counts as issued. With no pair presented, issue0, issue1, slip and pair_advance are all 0.
- R2: If both slots are valid and outstanding, of different classes (slot_fp bit 1 = floating-point ALU, 0 = general), and need no busy unit, both issue in the same cycle and pair_advance is 1.
- R3: If both outstanding slots have the same class, only slot 0 issues that cycle. Slot 1 issues in a later cycle, and pair_advance rises then.
- R4: issue1 is never 1 while slot 0 of the same pair is valid, not yet issued and not issuing.
- R5: Unit codes are 2'b00 none, 2'b01 FP divide/sqrt, 2'b10 integer multiply/divide, and 2'b11 is treated as none. An outstanding slot that needs a busy unit does not issue. slip is 1 when the oldest outstanding slot is held for that reason, and it is 0 otherwise.
- R6: After an operation for a unit issues in cycle t, no further operation for that unit issues before cycle t+LAT. LAT is FDIV_LAT or IMUL_LAT. At cycle t+LAT such an operation may issue.
- R7: A pair whose slot 0 is invalid (an odd branch target) offers only slot 1. That slot issues alone and advances the pair.
- R8: If both outstanding slots need the same long-latency unit, slot 1 does not issue in the cycle slot 0 does.
- R9: pair_advance is 1 exactly in the cycle when every valid slot of the pair has issued, either in that cycle or earlier. A slot that issued earlier is not issued again while the pair is held.
- R10: With pair_valid at 0, nothing issues and pair_advance is 0, while the busy counters keep counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_valid | input | 1 | A fetch pair is presented |
| slot_valid | input | 2 | Per-slot valid; bit 0 is the older slot |
| slot_fp | input | 2 | Per-slot class bit, 1 = floating-point ALU |
| slot0_unit | input | 2 | Long-latency unit needed by slot 0 |
| slot1_unit | input | 2 | Long-latency unit needed by slot 1 |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| slip | output | 1 | Oldest outstanding slot held by a busy unit |
| pair_advance | output | 1 | Pair fully issued; fetch may move on |

## Verification
The bench goes after the cycle in which a busy counter reaches zero. A counter loaded with the wrong value, or an off-by-one compare, lets a second divide issue a cycle early or holds it one cycle too long. It also holds slot 0 on a busy unit while slot 1 is free, which a design without ordering would let slot 1 overtake. It replays pairs after a partial issue, which a design that forgets issued slots would issue twice, and which a design that drops them would advance early. Pairs whose two slots need the same unit catch a design that double-books that unit.

// File: rtl/slot_issue_pkg.sv
package slot_issue_pkg;
  typedef enum logic [1:0] {
    UNIT_NONE = 2'b00,
    UNIT_FDIV = 2'b01,
    UNIT_IMUL = 2'b10,
    UNIT_RSVD = 2'b11
  } unit_e;

  localparam int NUM_UNITS = 2;
  localparam int NUM_SLOTS = 2;

  // unit code owned by tracker index u
  function automatic unit_e unit_of_index(input int u);
    return (u == 0) ? UNIT_FDIV : UNIT_IMUL;
  endfunction

  function automatic logic is_long(input unit_e k);
    return (k == UNIT_FDIV) || (k == UNIT_IMUL);
  endfunction
endpackage

// File: rtl/unit_busy_ctr.sv
module unit_busy_ctr #(
  parameter int LAT = 8,
  localparam int W = (LAT < 2) ? 1 : $clog2(LAT)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= W'(LAT - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/slot_pair_arb.sv
module slot_pair_arb (
  input  logic       pend0,
  input  logic       pend1,
  input  logic       fp0,
  input  logic       fp1,
  input  logic       held0,
  input  logic       held1,
  input  logic       share_unit,
  output logic       grant0,
  output logic       grant1,
  output logic       slip
);
  logic pair_ok;

  always_comb begin
    grant0  = pend0 && !held0;
    // younger may go only beside an issuing older of the other class
    pair_ok = !pend0 || (grant0 && (fp0 != fp1) && !share_unit);
    grant1  = pend1 && !held1 && pair_ok;
    slip    = pend0 ? held0 : (pend1 && held1);
  end
endmodule

// File: rtl/slot_issue_ctl.sv
module slot_issue_ctl
  import slot_issue_pkg::*;
#(
  parameter int FDIV_LAT = 12,
  parameter int IMUL_LAT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pair_valid,
  input  logic [1:0] slot_valid,
  input  logic [1:0] slot_fp,
  input  logic [1:0] slot0_unit,
  input  logic [1:0] slot1_unit,
  output logic       issue0,
  output logic       issue1,
  output logic       slip,
  output logic       pair_advance
);
  unit_e                k0, k1;
  logic [NUM_SLOTS-1:0] done_q;
  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_UNITS-1:0] busy_vec;
  logic                 held0, held1;
  logic                 share_unit;

  assign k0 = unit_e'(slot0_unit);
  assign k1 = unit_e'(slot1_unit);

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++)
      pend[s] = pair_valid && slot_valid[s] && !done_q[s];
  end

  always_comb begin
    held0 = 1'b0;
    held1 = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (k0 == unit_of_index(u) && busy_vec[u]) held0 = 1'b1;
      if (k1 == unit_of_index(u) && busy_vec[u]) held1 = 1'b1;
    end
    share_unit = is_long(k0) && (k0 == k1);
  end

  slot_pair_arb u_arb (
    .pend0      (pend[0]),
    .pend1      (pend[1]),
    .fp0        (slot_fp[0]),
    .fp1        (slot_fp[1]),
    .held0      (held0),
    .held1      (held1),
    .share_unit (share_unit),
    .grant0     (issue0),
    .grant1     (issue1),
    .slip       (slip)
  );

  assign pair_advance = pair_valid && (!pend[0] || issue0) && (!pend[1] || issue1);

  always_ff @(posedge clk) begin
    if (rst)
      done_q <= '0;
    else if (pair_advance)
      done_q <= '0;
    else
      done_q <= done_q | {issue1, issue0};
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int LAT_U = (u == 0) ? FDIV_LAT : IMUL_LAT;
    logic ld;
    assign ld = (issue0 && k0 == unit_of_index(u)) ||
                (issue1 && k1 == unit_of_index(u));
    unit_busy_ctr #(.LAT(LAT_U)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .load (ld),
      .busy (busy_vec[u])
    );
  end
endmodule

// File: rtl/slot_issue_ctl_chk.sv
module slot_issue_ctl_chk #(
  parameter int FDIV_LAT = 12,
  parameter int IMUL_LAT = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       pair_valid,
  input logic [1:0] slot_valid,
  input logic [1:0] slot_fp,
  input logic [1:0] slot0_unit,
  input logic [1:0] slot1_unit,
  input logic       issue0,
  input logic       issue1,
  input logic       slip,
  input logic       pair_advance,
  input logic [1:0] done_q
);
  logic fdiv_go, imul_go, pend0;
  assign fdiv_go = (issue0 && slot0_unit == 2'b01) || (issue1 && slot1_unit == 2'b01);
  assign imul_go = (issue0 && slot0_unit == 2'b10) || (issue1 && slot1_unit == 2'b10);
  assign pend0   = pair_valid && slot_valid[0] && !done_q[0];

  a_r3_one_per_class: assert property (@(posedge clk) disable iff (rst)
    (issue0 && issue1) |-> (slot_fp[0] != slot_fp[1]));

  a_r4_in_order: assert property (@(posedge clk) disable iff (rst)
    (pend0 && !issue0) |-> !issue1);

  a_r5_slip_blocks: assert property (@(posedge clk) disable iff (rst)
    slip |-> (!issue0 && !issue1));

  a_r8_unit_shared: assert property (@(posedge clk) disable iff (rst)
    (issue0 && issue1) |-> !(slot0_unit == slot1_unit && (slot0_unit == 2'b01 || slot0_unit == 2'b10)));

  a_r9_forget_on_advance: assert property (@(posedge clk) disable iff (rst)
    pair_advance |=> (done_q == 2'b00));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> (!issue0 && !issue1 && !pair_advance));

  if (FDIV_LAT > 1) begin : g_fd
    a_r6_fdiv_gap: assert property (@(posedge clk) disable iff (rst)
      fdiv_go |=> !fdiv_go);
  end
  if (IMUL_LAT > 1) begin : g_im
    a_r6_imul_gap: assert property (@(posedge clk) disable iff (rst)
      imul_go |=> !imul_go);
  end
endmodule

bind slot_issue_ctl slot_issue_ctl_chk #(.FDIV_LAT(FDIV_LAT), .IMUL_LAT(IMUL_LAT)) u_chk (
  .clk(clk), .rst(rst), .pair_valid(pair_valid), .slot_valid(slot_valid),
  .slot_fp(slot_fp), .slot0_unit(slot0_unit), .slot1_unit(slot1_unit),
  .issue0(issue0), .issue1(issue1), .slip(slip), .pair_advance(pair_advance),
  .done_q(done_q)
);

// File: tb/slot_issue_ctl_test.sv
`timescale 1ns/100ps
module slot_issue_ctl_test;
  localparam int FL = 6;
  localparam int IL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pv = 1'b0;
  logic [1:0] sv = 2'b00, sfp = 2'b00, u0 = 2'b00, u1 = 2'b00;
  logic i0, i1, sl, adv;

  int checks = 0;
  int errors = 0;

  // reference state
  int d0 = 0, d1 = 0, cf = 0, ci = 0;
  bit exp_adv;

  always #2.5 clk = ~clk;

  slot_issue_ctl #(.FDIV_LAT(FL), .IMUL_LAT(IL)) uut (
    .clk(clk), .rst(rst), .pair_valid(pv), .slot_valid(sv), .slot_fp(sfp),
    .slot0_unit(u0), .slot1_unit(u1),
    .issue0(i0), .issue1(i1), .slip(sl), .pair_advance(adv)
  );

  function automatic bit unit_busy(input logic [1:0] k);
    return (k == 2'b01 && cf != 0) || (k == 2'b10 && ci != 0);
  endfunction

  task automatic chk(input string tag, input string nm, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, step model, wait for next negedge
  task automatic cyc(input bit p, input logic [1:0] v, input logic [1:0] f,
                     input logic [1:0] k0, input logic [1:0] k1, input string tag);
    bit p0, p1, e0, e1, es, ea, b0, b1, shr;
    pv = p; sv = v; sfp = f; u0 = k0; u1 = k1;
    #1;
    p0 = p && v[0] && d0 == 0;
    p1 = p && v[1] && d1 == 0;
    b0 = unit_busy(k0);
    b1 = unit_busy(k1);
    shr = (k0 == k1) && (k0 == 2'b01 || k0 == 2'b10);
    e0 = p0 && !b0;
    e1 = p1 && !b1 && (!p0 || (e0 && f[0] != f[1] && !shr));
    es = p0 ? b0 : (p1 && b1);
    ea = p && (!p0 || e0) && (!p1 || e1);
    chk(tag, "issue0", i0, e0);
    chk(tag, "issue1", i1, e1);
    chk(tag, "slip", sl, es);
    chk(tag, "pair_advance", adv, ea);
    exp_adv = ea;
    if (ea) begin d0 = 0; d1 = 0; end
    else begin d0 = d0 | int'(e0); d1 = d1 | int'(e1); end
    if ((e0 && k0 == 2'b01) || (e1 && k1 == 2'b01)) cf = FL - 1;
    else if (cf > 0) cf--;
    if ((e0 && k0 == 2'b10) || (e1 && k1 == 2'b10)) ci = IL - 1;
    else if (ci > 0) ci--;
    @(negedge clk);
  endtask

  // present a pair until the model says it advances; returns cycles used
  task automatic run_pair(input logic [1:0] v, input logic [1:0] f,
                          input logic [1:0] k0, input logic [1:0] k1,
                          input string tag, output int ncyc);
    ncyc = 0;
    exp_adv = 1'b0;
    while (!exp_adv && ncyc < 60) begin
      cyc(1'b1, v, f, k0, k1, tag);
      ncyc++;
    end
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int n;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state, nothing presented
    cyc(1'b0, 2'b11, 2'b01, 2'b00, 2'b00, "R1");
    // R2: mixed classes issue together
    run_pair(2'b11, 2'b10, 2'b00, 2'b00, "R2", n);
    checks++; if (n != 1) begin errors++; $display("FAIL R2 cycles actual=%0d expected=1", n); end
    // R3: same class serialises
    run_pair(2'b11, 2'b00, 2'b00, 2'b00, "R3", n);
    checks++; if (n != 2) begin errors++; $display("FAIL R3 cycles actual=%0d expected=2", n); end
    run_pair(2'b11, 2'b11, 2'b00, 2'b11, "R3", n);
    // R6: back-to-back FP divides spaced by FL
    run_pair(2'b01, 2'b01, 2'b01, 2'b00, "R6", n);
    run_pair(2'b01, 2'b01, 2'b01, 2'b00, "R6", n);
    checks++; if (n != FL) begin errors++; $display("FAIL R6 cycles actual=%0d expected=%0d", n, FL); end
    // R5: integer unit busy, slot 0 slips
    run_pair(2'b01, 2'b00, 2'b10, 2'b00, "R5", n);
    run_pair(2'b11, 2'b10, 2'b10, 2'b00, "R5", n);
    checks++; if (n != IL) begin errors++; $display("FAIL R5 cycles actual=%0d expected=%0d", n, IL); end
    // R4: slot 0 slips on a busy unit, free slot 1 must wait
    run_pair(2'b11, 2'b10, 2'b10, 2'b00, "R4", n);
    // R7: odd entry, only slot 1
    run_pair(2'b10, 2'b10, 2'b00, 2'b00, "R7", n);
    checks++; if (n != 1) begin errors++; $display("FAIL R7 cycles actual=%0d expected=1", n); end
    // R8: both slots want the FP divider
    run_pair(2'b11, 2'b10, 2'b01, 2'b01, "R8", n);
    // R10: idle cycles while counters drain
    run_pair(2'b01, 2'b00, 2'b10, 2'b00, "R10", n);
    for (int k = 0; k < IL + 1; k++) cyc(1'b0, 2'b11, 2'b10, 2'b10, 2'b01, "R10");
    run_pair(2'b01, 2'b00, 2'b10, 2'b00, "R10", n);
    checks++; if (n != 1) begin errors++; $display("FAIL R10 cycles actual=%0d expected=1", n); end
    // R9: mixed traffic, pairs held until advance
    for (int k = 0; k < 400; k++) begin
      logic [1:0] rv, rf, r0, r1;
      rv = 2'($urandom_range(0, 3));
      rf = 2'($urandom_range(0, 3));
      r0 = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      r1 = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      if ($urandom_range(0, 7) == 0) cyc(1'b0, rv, rf, r0, r1, "R9");
      else run_pair(rv, rf, r0, r1, "R9", n);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule